// File: doc/BRIEF.md
# Two-Subframe TDM Slot Sequencer

This block produces the bit, channel and subframe timing of a time-division-multiplexed serial audio frame. A frame holds either one subframe or two, and each subframe has its own channel count, channel (slot) length and data word length. Because a word is always shorter than the slot that carries it, every channel ends with padding bits. A serial shifter that sits next to this block uses its outputs to decide which slot and which bit it is on, and whether that bit carries data.

Software writes a 32-bit configuration word. Two mode inputs choose between the one-subframe and the two-subframe frame and apply a 16-bit cap on word length. The sequencer moves forward only on cycles where the bit-clock enable is high. It takes on a new configuration only at a frame boundary, or while it is idle. A setting that breaks the length rules raises an error flag. Such a setting is never used, and the last legal setting stays in force.

Top module: `tdmSlotSeq`

## Requirements
- R1: The configuration word is written by `cfgWrEn` and read back on `cfgRdData`. Its fields are: bits 4-0 subframe 0 word length minus one, bits 9-5 subframe 0 channel length minus one, bits 14-10 subframe 0 channel count minus one, bits 20-16 subframe 1 word length minus one, bits 25-21 subframe 1 channel length minus one, and bits 30-26 subframe 1 channel count minus one. Bits 31 and 15 always read zero.
- R2: Each clock with `bitEn` high moves `bitPos` forward by one, and the new value shows after that clock edge. With `bitEn` low, none of the position outputs change.
- R3: After the last bit of a channel (`bitPos` equal to the channel length field), the next step sets `bitPos` to 0 and increments `chanIdx`. After the last channel (`chanIdx` equal to the count field), the sequencer moves on to subframe 1, channel 0 when two-subframe mode is active, and otherwise starts the next frame at subframe 0.
- R4: When `twoSubIn` is low, `subIdx` stays 0 and the subframe 1 fields have no effect on either timing or `cfgError`.
- R5: `wordValid` is high while running and `bitPos` is less than or equal to the word length field of the current subframe. It is low on the padding bits.
- R6: `frameStart` is high exactly while the sequencer runs at subframe 0, channel 0, bit 0.
- R7: A subframe setting is legal when its channel length field is at least 6, its word length field is at least 6, the word length field is strictly less than the channel length field, and, when `halfWordIn` is high, the word length field is at most 15. Subframe 1 is checked only when `twoSubIn` is high. `cfgError` shows whether the pending setting is illegal, one clock after the register or the mode inputs change.
- R8: The register fields and mode inputs take effect only on a `bitEn` step taken from the last bit of a frame, or on a step taken while idle. Within a frame the timing follows the configuration that was loaded at its start.
- R9: If the pending setting is illegal at a boundary, the previous legal configuration is kept and a new frame starts with it. If no legal setting has ever been loaded, the sequencer stays idle with all position outputs, `wordValid` and `frameStart` at zero.
- R10: After reset the sequencer is idle, every output is zero, and the register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 32 | Configuration word to write |
| twoSubIn | input | 1 | 1: frame of two subframes, 0: subframe 0 only |
| halfWordIn | input | 1 | 1: word length limited to 16 bits |
| bitEn | input | 1 | Bit-clock enable; one bit step per high cycle |
| cfgRdData | output | 32 | Register read-back, reserved bits zero |
| cfgError | output | 1 | Pending setting is illegal |
| frameStart | output | 1 | First bit of the frame |
| subIdx | output | 1 | Current subframe |
| chanIdx | output | 5 | Current channel within the subframe |
| bitPos | output | 5 | Current bit within the channel |
| wordValid | output | 1 | Current bit lies inside the data word |

## Verification
The position counters feed every output, so a fault in wrap handling shows at once. A wrong wrap value makes `bitPos` or `chanIdx` leave the expected sequence on the very next enabled step, and `frameStart` and `wordValid` then drift for the rest of the frame. A configuration that loads at the wrong time produces a channel length or word/padding split that is visibly wrong within one channel after the load, while a failure to reject an illegal setting shows up only at the next frame boundary. For this reason the bench compares all position outputs after every step against its own model across several full frames, including frames that follow writes made mid-frame and writes of illegal settings.

// File: rtl/tdmSlotPkg.sv
package tdmSlotPkg;
  localparam int FieldW     = 5;
  localparam int RegW       = 32;
  localparam int SubW       = 3 * FieldW;
  localparam int Sub1Lsb    = SubW + 1;
  localparam int MinLenFld  = 6;   // 7 bits
  localparam int HalfMaxFld = 15;  // 16 bits

  typedef struct packed {
    logic [FieldW-1:0] chanCnt;
    logic [FieldW-1:0] chanLen;
    logic [FieldW-1:0] wordLen;
  } subCfgT;

  typedef struct packed {
    logic   twoSub;
    logic   halfWord;
    subCfgT sub1;
    subCfgT sub0;
  } actCfgT;

  typedef struct packed {
    logic loadCfg;
    logic clrPos;
    logic incBit;
    logic nextChan;
    logic nextSub;
  } seqStrobeT;

  function automatic logic subLegal(subCfgT s, logic half);
    return (s.chanLen >= FieldW'(MinLenFld)) &&
           (s.wordLen >= FieldW'(MinLenFld)) &&
           (s.wordLen <  s.chanLen) &&
           (!half || (s.wordLen <= FieldW'(HalfMaxFld)));
  endfunction
endpackage

// File: rtl/tdmSeqCtrl.sv
module tdmSeqCtrl
  import tdmSlotPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      pendValid,
  input  logic      atChanEnd,
  input  logic      atSubLast,
  input  logic      atFrameEnd,
  output seqStrobeT strobe,
  output logic      running
);
  logic runNext;

  always_comb begin
    strobe  = '0;
    runNext = running;
    if (bitEn) begin
      if (!running || atFrameEnd) begin
        if (pendValid) begin
          strobe.loadCfg = 1'b1;
          strobe.clrPos  = 1'b1;
          runNext        = 1'b1;
        end else if (running) begin
          strobe.clrPos = 1'b1;
        end
      end else if (atChanEnd) begin
        if (atSubLast) strobe.nextSub  = 1'b1;
        else           strobe.nextChan = 1'b1;
      end else begin
        strobe.incBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= runNext;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrPos, strobe.incBit, strobe.nextChan, strobe.nextSub})); // R3
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running); // R9
  AST_NO_STEP_IDLE_EN: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(running)); // R2
endmodule

// File: rtl/tdmSeqData.sv
module tdmSeqData
  import tdmSlotPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [RegW-1:0]   cfgWrData,
  input  logic              twoSubIn,
  input  logic              halfWordIn,
  input  seqStrobeT         strobe,
  input  logic              running,
  output logic [RegW-1:0]   cfgRdData,
  output logic              cfgError,
  output logic              pendValid,
  output logic              atChanEnd,
  output logic              atSubLast,
  output logic              atFrameEnd,
  output logic              frameStart,
  output logic              subIdx,
  output logic [FieldW-1:0] chanIdx,
  output logic [FieldW-1:0] bitPos,
  output logic              wordValid
);
  logic [SubW-1:0] shadow0;
  logic [SubW-1:0] shadow1;
  actCfgT          pendCfg;
  actCfgT          actCfg;
  subCfgT          curSub;

  // Shadow register; reserved bits are never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow0 <= '0;
      shadow1 <= '0;
    end else if (cfgWrEn) begin
      shadow0 <= cfgWrData[SubW-1:0];
      shadow1 <= cfgWrData[Sub1Lsb +: SubW];
    end
  end

  assign cfgRdData = {1'b0, shadow1, 1'b0, shadow0};

  always_comb begin
    pendCfg.twoSub   = twoSubIn;
    pendCfg.halfWord = halfWordIn;
    pendCfg.sub0     = subCfgT'(shadow0);
    pendCfg.sub1     = subCfgT'(shadow1);
  end

  assign pendValid = subLegal(pendCfg.sub0, halfWordIn) &&
                     (!twoSubIn || subLegal(pendCfg.sub1, halfWordIn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgError <= 1'b0;
    else       cfgError <= !pendValid;
  end

  // Active configuration, replaced only by a boundary load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               actCfg <= '0;
    else if (strobe.loadCfg) actCfg <= pendCfg;
  end

  assign curSub     = subIdx ? actCfg.sub1 : actCfg.sub0;
  assign atChanEnd  = (bitPos == curSub.chanLen);
  assign atSubLast  = (chanIdx == curSub.chanCnt);
  assign atFrameEnd = running && atChanEnd && atSubLast && (subIdx || !actCfg.twoSub);

  // Position counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subIdx  <= 1'b0;
      chanIdx <= '0;
      bitPos  <= '0;
    end else if (strobe.clrPos) begin
      subIdx  <= 1'b0;
      chanIdx <= '0;
      bitPos  <= '0;
    end else if (strobe.nextSub) begin
      subIdx  <= 1'b1;
      chanIdx <= '0;
      bitPos  <= '0;
    end else if (strobe.nextChan) begin
      chanIdx <= chanIdx + 1'b1;
      bitPos  <= '0;
    end else if (strobe.incBit) begin
      bitPos  <= bitPos + 1'b1;
    end
  end

  assign wordValid  = running && (bitPos <= curSub.wordLen);
  assign frameStart = running && !subIdx && (chanIdx == '0) && (bitPos == '0);

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> bitPos <= curSub.chanLen); // R3
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> chanIdx <= curSub.chanCnt); // R3
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incBit |=> bitPos == $past(bitPos) + 5'd1); // R2
  AST_SUB1_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    subIdx |-> actCfg.twoSub); // R4
  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    running |-> subLegal(actCfg.sub0, actCfg.halfWord)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (running && (subIdx || chanIdx != '0 || bitPos != '0)) |-> $stable(actCfg)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!subIdx && chanIdx == '0 && bitPos == '0 && !wordValid)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[RegW-1] && !cfgRdData[SubW]); // R1
endmodule

// File: rtl/tdmSlotSeq.sv
module tdmSlotSeq
  import tdmSlotPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [RegW-1:0]   cfgWrData,
  input  logic              twoSubIn,
  input  logic              halfWordIn,
  input  logic              bitEn,
  output logic [RegW-1:0]   cfgRdData,
  output logic              cfgError,
  output logic              frameStart,
  output logic              subIdx,
  output logic [FieldW-1:0] chanIdx,
  output logic [FieldW-1:0] bitPos,
  output logic              wordValid
);
  seqStrobeT strobe;
  logic      running;
  logic      pendValid;
  logic      atChanEnd;
  logic      atSubLast;
  logic      atFrameEnd;

  tdmSeqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .pendValid  (pendValid),
    .atChanEnd  (atChanEnd),
    .atSubLast  (atSubLast),
    .atFrameEnd (atFrameEnd),
    .strobe     (strobe),
    .running    (running)
  );

  tdmSeqData uData (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .twoSubIn   (twoSubIn),
    .halfWordIn (halfWordIn),
    .strobe     (strobe),
    .running    (running),
    .cfgRdData  (cfgRdData),
    .cfgError   (cfgError),
    .pendValid  (pendValid),
    .atChanEnd  (atChanEnd),
    .atSubLast  (atSubLast),
    .atFrameEnd (atFrameEnd),
    .frameStart (frameStart),
    .subIdx     (subIdx),
    .chanIdx    (chanIdx),
    .bitPos     (bitPos),
    .wordValid  (wordValid)
  );
endmodule

// File: tb/tdmSlotSeq_test.sv
module tdmSlotSeq_test;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        twoSubIn = 1'b0;
  logic        halfWordIn = 1'b0;
  logic        bitEn = 1'b0;
  logic [31:0] cfgRdData;
  logic        cfgError;
  logic        frameStart;
  logic        subIdx;
  logic [4:0]  chanIdx;
  logic [4:0]  bitPos;
  logic        wordValid;

  int errors = 0;
  int checks = 0;

  // Bench model
  logic [31:0] pendVal = '0;
  bit          pendTwo = 0;
  bit          pendHalf = 0;
  bit mRun = 0;
  int mSub = 0, mChan = 0, mBit = 0;
  int mCnt [2];
  int mCh  [2];
  int mWd  [2];
  bit mTwo = 0;
  bit sawSub1 = 0;

  always #(ClkPeriod/2) clk = ~clk;

  tdmSlotSeq uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .twoSubIn(twoSubIn), .halfWordIn(halfWordIn), .bitEn(bitEn),
    .cfgRdData(cfgRdData), .cfgError(cfgError), .frameStart(frameStart),
    .subIdx(subIdx), .chanIdx(chanIdx), .bitPos(bitPos), .wordValid(wordValid)
  );

  function automatic bit okSub(int cnt, int ch, int wd, bit half);
    return (ch >= 6) && (wd >= 6) && (wd < ch) && (!half || wd <= 15) && (cnt >= 0);
  endfunction

  function automatic bit okAll(logic [31:0] v, bit two, bit half);
    return okSub(int'(v[14:10]), int'(v[9:5]), int'(v[4:0]), half) &&
           (!two || okSub(int'(v[30:26]), int'(v[25:21]), int'(v[20:16]), half));
  endfunction

  function automatic logic [31:0] mkCfg(int c1, int l1, int w1, int c0, int l0, int w0);
    return {1'b0, 5'(c1), 5'(l1), 5'(w1), 1'b0, 5'(c0), 5'(l0), 5'(w0)};
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  task automatic modelStep();
    bit fEnd;
    fEnd = mRun && mBit == mCh[mSub] && mChan == mCnt[mSub] && (mSub == 1 || !mTwo);
    if (!mRun || fEnd) begin
      if (okAll(pendVal, pendTwo, pendHalf)) begin
        mCnt[0] = int'(pendVal[14:10]); mCh[0] = int'(pendVal[9:5]);   mWd[0] = int'(pendVal[4:0]);
        mCnt[1] = int'(pendVal[30:26]); mCh[1] = int'(pendVal[25:21]); mWd[1] = int'(pendVal[20:16]);
        mTwo = pendTwo; mRun = 1;
        mSub = 0; mChan = 0; mBit = 0;
      end else if (mRun) begin
        mSub = 0; mChan = 0; mBit = 0;
      end
    end else if (mBit == mCh[mSub]) begin
      mBit = 0;
      if (mChan == mCnt[mSub]) begin mSub = 1; mChan = 0; end
      else mChan++;
    end else begin
      mBit++;
    end
  endtask

  task automatic compare(input string tag);
    bit eWv, eFs;
    eWv = mRun && (mBit <= mWd[mSub]);
    eFs = mRun && mSub == 0 && mChan == 0 && mBit == 0;
    checks++;
    if ({subIdx, chanIdx, bitPos, wordValid, frameStart} !==
        {1'(mSub), 5'(mChan), 5'(mBit), eWv, eFs}) begin
      errors++;
      $display("FAIL %s position actual sub=%0d ch=%0d bit=%0d wv=%0b fs=%0b expected sub=%0d ch=%0d bit=%0d wv=%0b fs=%0b",
               tag, subIdx, chanIdx, bitPos, wordValid, frameStart, mSub, mChan, mBit, eWv, eFs);
    end
    if (subIdx === 1'b1) sawSub1 = 1;
  endtask

  task automatic pulse(input string tag);
    @(negedge clk) bitEn = 1'b1;
    @(negedge clk) bitEn = 1'b0;
    modelStep();
    compare(tag);
  endtask

  task automatic writeCfg(input logic [31:0] v, input bit two, input bit half);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v; twoSubIn = two; halfWordIn = half;
    @(negedge clk);
    cfgWrEn = 1'b0;
    pendVal = v & 32'h7FFF7FFF; pendTwo = two; pendHalf = half;
    @(negedge clk);
  endtask

  task automatic tReset();
    checkVal("R10", "cfgRdData", int'(cfgRdData), 0);
    checkVal("R10", "cfgError", int'(cfgError), 0);
    checkVal("R10", "positions", int'({frameStart, subIdx, chanIdx, bitPos, wordValid}), 0);
  endtask

  task automatic tRegAccess();
    writeCfg(32'hFFFF_FFFF, 1'b0, 1'b0);
    checkVal("R1", "readback all ones", int'(cfgRdData), int'(32'h7FFF7FFF));
    checkVal("R7", "error word equals channel", int'(cfgError), 1);
    writeCfg(32'h9234_D678, 1'b0, 1'b0);
    checkVal("R1", "readback pattern", int'(cfgRdData), int'(32'h1234_5678));
    writeCfg(mkCfg(0, 5, 6, 0, 5, 4), 1'b0, 1'b0);
    checkVal("R7", "error channel of 6 bits", int'(cfgError), 1);
    for (int i = 0; i < 3; i++) pulse("R9");
  endtask

  task automatic tOneSub();
    // subframe 1 deliberately illegal: must be ignored
    writeCfg(mkCfg(3, 2, 9, 1, 7, 6), 1'b0, 1'b0);
    checkVal("R4", "error with unused sub1 illegal", int'(cfgError), 0);
    pulse("R8");
    checkVal("R6", "frameStart on first bit", int'(frameStart), 1);
    for (int i = 0; i < 40; i++) pulse("R3");
    checkVal("R4", "never subframe 1", int'(sawSub1), 0);
    begin
      logic [11:0] snap;
      snap = {subIdx, chanIdx, bitPos, wordValid};
      repeat (4) @(negedge clk);
      checkVal("R2", "stable without enable", int'({subIdx, chanIdx, bitPos, wordValid}), int'(snap));
    end
  endtask

  task automatic tTwoSub();
    for (int i = 0; i < 3; i++) pulse("R3");
    writeCfg(mkCfg(2, 11, 7, 1, 7, 6), 1'b1, 1'b0);
    checkVal("R7", "legal two-sub setting", int'(cfgError), 0);
    for (int i = 0; i < 20; i++) pulse("R8");
    for (int i = 0; i < 130; i++) pulse("R5");
    checkVal("R3", "reached subframe 1", int'(sawSub1), 1);
  endtask

  task automatic tBadHold();
    writeCfg(mkCfg(2, 11, 7, 0, 24, 20), 1'b1, 1'b1);
    checkVal("R7", "half-word cap exceeded", int'(cfgError), 1);
    for (int i = 0; i < 120; i++) pulse("R9");
    writeCfg(mkCfg(2, 11, 11, 0, 24, 15), 1'b1, 1'b1);
    checkVal("R7", "sub1 word equals channel", int'(cfgError), 1);
    writeCfg(mkCfg(0, 8, 7, 0, 31, 30), 1'b1, 1'b0);
    checkVal("R7", "max legal lengths", int'(cfgError), 0);
    for (int i = 0; i < 150; i++) pulse("R5");
    writeCfg(mkCfg(0, 8, 7, 0, 24, 15), 1'b0, 1'b1);
    checkVal("R7", "half-word at 16 bits legal", int'(cfgError), 0);
    for (int i = 0; i < 120; i++) pulse("R6");
  endtask

  initial begin
    #(ClkPeriod * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mCnt[0] = 0; mCnt[1] = 0; mCh[0] = 0; mCh[1] = 0; mWd[0] = 0; mWd[1] = 0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tRegAccess();
    tOneSub();
    tTwoSub();
    tBadHold();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule